// File: doc/BRIEF.md
# Watchdog Timer with Keyed Start/Stop and Posted Writes

This block is a watchdog timer for a system chip. A counter driven by a slow 32.768 kHz timebase counts upward from a programmable load value. If software does not service it before the counter passes its all-ones value, the block drives a reset pulse to the rest of the chip. A CPU controls the block through a simple memory-mapped register bus clocked by a fast bus clock.

The counter can only be started or stopped by writing a two-word key sequence to a dedicated arming register. Any other word breaks the sequence, so one stray write cannot disable the watchdog. Software services the watchdog by writing a kick register. The counter reloads only when the new kick value differs from the previous one, which is why software alternates a pattern with its complement.

Writes that cross into the slow domain are posted through toggle handshakes. Each of the three slow-domain registers has its own pending bit, and software must poll that bit before writing the register again. The counter, the load value and the run/cause state come back to the bus domain as one coherent snapshot. A read therefore never returns a torn value.

Top module: `wdt_unlock`

## Requirements
- R1: After `rst_ni` is released, STATUS reads 0, PEND reads 0, and both LOAD and COUNT read the default load 0xFFF00000. This is 2^32 − 32·32768, which gives a 32 s timeout at 32768 counts per second. ID reads the `ID_VALUE` parameter and `wdt_rst_o` is low.
- R2: While running, the counter advances by one on each slow clock edge. About 100 slow cycles of running raise COUNT by 90 to 110.
- R3: Writing 0x0000BBBB and then 0x00004444 to ARM (byte offset 0x18) loads the counter from LOAD and sets STATUS bit 0 (run). A repeated 0x0000BBBB re-arms the first step.
- R4: Writing 0x0000AAAA and then 0x00005555 to ARM clears the run bit. COUNT then stays frozen.
- R5: An ARM word that neither completes nor starts a sequence returns the checker to idle, and the run state does not change.
- R6: PEND (byte offset 0x14) has three pending bits: bit 2 for LOAD, bit 3 for KICK and bit 4 for ARM. Each bit is set from the accepted write until the slow domain has applied it. All other PEND bits read 0.
- R7: A write to LOAD, KICK or ARM while that register's pending bit is set is dropped.
- R8: A KICK write (byte offset 0x10) whose value differs from the last accepted kick value reloads the counter from LOAD. The last accepted value is 0 after reset. A value equal to the last one has no effect and sets no pending bit.
- R9: When the running counter passes 0xFFFFFFFF, `wdt_rst_o` goes high for exactly `RST_CYCLES` slow cycles. The same event clears the run bit, returns LOAD and COUNT to 0xFFF00000, and sets STATUS bit 1 (cause). The cause bit stays set until `rst_ni`.
- R10: COUNT (byte offset 0x08) returns a coherent snapshot of the counter. Successive reads during running are strictly increasing.
- R11: Read data appears on `bus_rdata_o` in the cycle after the read request and holds until the next read. The register byte offsets are ID 0x00, STATUS 0x04 and LOAD 0x0C. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| slow_clk_i | input | 1 | 32.768 kHz timebase clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| wdt_rst_o | output | 1 | Watchdog reset pulse, slow-clock domain |

## Verification
The hazards come in two kinds. A wrong sequence-checker state or a lost handshake toggle shows at the ports as a run bit that never changes, or as a PEND bit that stays set. Either one is visible in the first STATUS or PEND read after the key writes, a few slow cycles later. A wrong counter or reload path shows as a COUNT rate outside its window, as a kick that fails to pull COUNT back near LOAD, or as a reset pulse that is missing, premature or of the wrong length. The bench compares `wdt_rst_o` against its model on every bus clock, so a spurious reset is caught within one cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2
  } wdt_cmd_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ON   = 2'd1,
    SEQ_OFF  = 2'd2
  } wdt_seq_e;

  localparam logic [15:0] KEY_ON1  = 16'hBBBB;
  localparam logic [15:0] KEY_ON2  = 16'h4444;
  localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [15:0] KEY_OFF2 = 16'h5555;

  localparam int OFF_ID     = 'h00;
  localparam int OFF_STATUS = 'h04;
  localparam int OFF_COUNT  = 'h08;
  localparam int OFF_LOAD   = 'h0C;
  localparam int OFF_KICK   = 'h10;
  localparam int OFF_PEND   = 'h14;
  localparam int OFF_ARM    = 'h18;

  localparam int PEND_LOAD_BIT = 2;
  localparam int PEND_KICK_BIT = 3;
  localparam int PEND_ARM_BIT  = 4;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;
endmodule

// File: rtl/wdt_post_chan.sv
module wdt_post_chan #(
  parameter int W = 32
) (
  input  logic         s_clk_i,
  input  logic         s_rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  input  logic         d_clk_i,
  input  logic         d_rst_ni,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         req_q, req_d;
  logic [W-1:0] hold_q, hold_d;
  logic         ack_m_q, ack_s_q;
  logic         req_m_q, req_s_q, ack_q;
  logic         accept;

  // source side: next state
  always_comb begin
    accept = push_i & ~busy_o;
    req_d  = req_q ^ accept;
    hold_d = accept ? data_i : hold_q;
  end

  always_ff @(posedge s_clk_i or negedge s_rst_ni) begin
    if (!s_rst_ni) begin
      req_q   <= 1'b0;
      hold_q  <= '0;
      ack_m_q <= 1'b0;
      ack_s_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      hold_q  <= hold_d;
      ack_m_q <= ack_q;
      ack_s_q <= ack_m_q;
    end
  end

  assign busy_o = req_q ^ ack_s_q;

  // destination side
  always_ff @(posedge d_clk_i or negedge d_rst_ni) begin
    if (!d_rst_ni) begin
      req_m_q <= 1'b0;
      req_s_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      req_m_q <= req_q;
      req_s_q <= req_m_q;
      ack_q   <= req_s_q;
    end
  end

  assign valid_o = req_s_q ^ ack_q;
  assign data_o  = hold_q;

  // R7
  hold_stable_chk: assert property (@(posedge s_clk_i) disable iff (!s_rst_ni)
    (busy_o && push_i) |=> $stable(hold_q));

  // R6
  valid_pulse_chk: assert property (@(posedge d_clk_i) disable iff (!d_rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/wdt_seq_check.sv
module wdt_seq_check
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output wdt_cmd_e          cmd_o
);
  wdt_seq_e state_q, state_d;
  logic is_on1, is_on2, is_off1, is_off2;

  always_comb begin
    is_on1  = (data_i == DATA_W'(KEY_ON1));
    is_on2  = (data_i == DATA_W'(KEY_ON2));
    is_off1 = (data_i == DATA_W'(KEY_OFF1));
    is_off2 = (data_i == DATA_W'(KEY_OFF2));
  end

  always_comb begin
    state_d = state_q;
    cmd_o   = CMD_NONE;
    if (wr_i) begin
      if (is_on1) begin
        state_d = SEQ_ON;
      end else if (is_off1) begin
        state_d = SEQ_OFF;
      end else if (is_on2 && state_q == SEQ_ON) begin
        cmd_o   = CMD_START;
        state_d = SEQ_IDLE;
      end else if (is_off2 && state_q == SEQ_OFF) begin
        cmd_o   = CMD_STOP;
        state_d = SEQ_IDLE;
      end else begin
        state_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  // R3
  arm_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_on1) |=> (state_q == SEQ_ON));

  // R5
  broken_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !is_on1 && !is_on2 && !is_off1 && !is_off2) |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int               CNT_W      = 32,
  parameter int               RST_CYCLES = 8,
  parameter logic [CNT_W-1:0] LOAD_DEF   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_v_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             kick_v_i,
  input  logic             kick_i,
  input  logic             cmd_v_i,
  input  logic [1:0]       cmd_i,
  output logic             run_o,
  output logic             cause_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output logic             wdt_rst_o
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q, run_d;
  logic             cause_q, cause_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic [RC_W-1:0]  rcnt_q, rcnt_d;
  logic             rst_q, rst_d;
  logic             wrap;

  always_comb begin
    wrap    = run_q && (cnt_q == CNT_MAX);
    run_d   = run_q;
    cause_d = cause_q;
    cnt_d   = cnt_q;
    load_d  = load_q;
    rcnt_d  = (rcnt_q != '0) ? rcnt_q - RC_W'(1) : rcnt_q;
    if (load_v_i) load_d = load_i;
    if (cmd_v_i && cmd_i == CMD_STOP) run_d = 1'b0;
    if (run_q) cnt_d = cnt_q + CNT_W'(1);
    if (kick_v_i && kick_i) cnt_d = load_d;
    if (cmd_v_i && cmd_i == CMD_START) begin
      run_d = 1'b1;
      cnt_d = load_d;
    end
    if (wrap) begin
      run_d   = 1'b0;
      cause_d = 1'b1;
      cnt_d   = LOAD_DEF;
      load_d  = LOAD_DEF;
      rcnt_d  = RC_W'(RST_CYCLES);
    end
    rst_d = (rcnt_d != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cause_q <= 1'b0;
      cnt_q   <= LOAD_DEF;
      load_q  <= LOAD_DEF;
      rcnt_q  <= '0;
      rst_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      cause_q <= cause_d;
      cnt_q   <= cnt_d;
      load_q  <= load_d;
      rcnt_q  <= rcnt_d;
      rst_q   <= rst_d;
    end
  end

  assign run_o     = run_q;
  assign cause_o   = cause_q;
  assign cnt_o     = cnt_q;
  assign load_o    = load_q;
  assign wdt_rst_o = rst_q;

  // R9
  wrap_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == CNT_MAX) |=> (rst_q && !run_q && cause_q && load_q == LOAD_DEF));

  // R4
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !kick_v_i && !cmd_v_i) |=> $stable(cnt_q));

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != CNT_MAX && !kick_v_i && !cmd_v_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R9
  cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_q |=> cause_q);
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int          ADDR_W        = 5,
  parameter int          DATA_W        = 32,
  parameter int          CNT_W         = 32,
  parameter int          TICKS_PER_S   = 32768,
  parameter int          DEF_TIMEOUT_S = 32,
  parameter int          RST_CYCLES    = 8,
  parameter logic [31:0] ID_VALUE      = 32'h5744_0001
) (
  input  logic              clk_i,
  input  logic              slow_clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wdt_rst_o
);
  localparam logic [CNT_W-1:0] LOAD_DEF =
    {CNT_W{1'b0}} - CNT_W'(DEF_TIMEOUT_S * TICKS_PER_S);
  localparam int SNAP_W = 2 + 2 * CNT_W;

  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'(OFF_KICK);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(OFF_ARM);

  logic f_rst_n, s_rst_n;
  logic wr_en, rd_en;
  logic push_load, push_kick, push_arm;
  logic load_busy, kick_busy, arm_busy;
  logic kick_same;
  wdt_cmd_e cmd;

  logic             load_v_s, kick_v_s, cmd_v_s, kick_s;
  logic [CNT_W-1:0] load_s;
  logic [1:0]       cmd_s;

  logic             run_s, cause_s, snap_busy, snap_v;
  logic [CNT_W-1:0] cnt_s, lreg_s;
  logic [SNAP_W-1:0] snap_src, snap_dst;

  logic [DATA_W-1:0] last_kick_q, last_kick_d;
  logic [SNAP_W-1:0] snap_q, snap_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux;

  logic             snap_run, snap_cause;
  logic [CNT_W-1:0] snap_cnt, snap_load;

  wdt_rst_sync u_fsync (.clk_i(clk_i),      .arst_ni(rst_ni), .rst_no(f_rst_n));
  wdt_rst_sync u_ssync (.clk_i(slow_clk_i), .arst_ni(rst_ni), .rst_no(s_rst_n));

  // bus decode
  always_comb begin
    wr_en     = bus_sel_i & bus_wr_i;
    rd_en     = bus_sel_i & ~bus_wr_i;
    kick_same = (bus_wdata_i == last_kick_q);
    push_load = wr_en && (bus_addr_i == A_LOAD) && !load_busy;
    push_kick = wr_en && (bus_addr_i == A_KICK) && !kick_busy && !kick_same;
    push_arm  = wr_en && (bus_addr_i == A_ARM)  && !arm_busy;
  end

  wdt_seq_check #(.DATA_W(DATA_W)) u_seq (
    .clk_i (clk_i),
    .rst_ni(f_rst_n),
    .wr_i  (push_arm),
    .data_i(bus_wdata_i),
    .cmd_o (cmd)
  );

  // posted writes into the slow domain
  wdt_post_chan #(.W(CNT_W)) u_load_chan (
    .s_clk_i(clk_i), .s_rst_ni(f_rst_n), .push_i(push_load),
    .data_i(CNT_W'(bus_wdata_i)), .busy_o(load_busy),
    .d_clk_i(slow_clk_i), .d_rst_ni(s_rst_n), .valid_o(load_v_s), .data_o(load_s)
  );

  wdt_post_chan #(.W(1)) u_kick_chan (
    .s_clk_i(clk_i), .s_rst_ni(f_rst_n), .push_i(push_kick),
    .data_i(1'b1), .busy_o(kick_busy),
    .d_clk_i(slow_clk_i), .d_rst_ni(s_rst_n), .valid_o(kick_v_s), .data_o(kick_s)
  );

  wdt_post_chan #(.W(2)) u_arm_chan (
    .s_clk_i(clk_i), .s_rst_ni(f_rst_n), .push_i(push_arm),
    .data_i(cmd), .busy_o(arm_busy),
    .d_clk_i(slow_clk_i), .d_rst_ni(s_rst_n), .valid_o(cmd_v_s), .data_o(cmd_s)
  );

  wdt_core #(
    .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES), .LOAD_DEF(LOAD_DEF)
  ) u_core (
    .clk_i    (slow_clk_i),
    .rst_ni   (s_rst_n),
    .load_v_i (load_v_s),
    .load_i   (load_s),
    .kick_v_i (kick_v_s),
    .kick_i   (kick_s),
    .cmd_v_i  (cmd_v_s),
    .cmd_i    (cmd_s),
    .run_o    (run_s),
    .cause_o  (cause_s),
    .cnt_o    (cnt_s),
    .load_o   (lreg_s),
    .wdt_rst_o(wdt_rst_o)
  );

  // coherent snapshot back into the bus domain
  assign snap_src = {cause_s, run_s, lreg_s, cnt_s};

  wdt_post_chan #(.W(SNAP_W)) u_snap_chan (
    .s_clk_i(slow_clk_i), .s_rst_ni(s_rst_n), .push_i(~snap_busy),
    .data_i(snap_src), .busy_o(snap_busy),
    .d_clk_i(clk_i), .d_rst_ni(f_rst_n), .valid_o(snap_v), .data_o(snap_dst)
  );

  assign {snap_cause, snap_run, snap_load, snap_cnt} = snap_q;

  // bus-domain next state
  always_comb begin
    last_kick_d = push_kick ? bus_wdata_i : last_kick_q;
    snap_d      = snap_v ? snap_dst : snap_q;
    rd_mux      = '0;
    case (bus_addr_i)
      A_ID:     rd_mux = DATA_W'(ID_VALUE);
      A_STATUS: begin
        rd_mux[0] = snap_run;
        rd_mux[1] = snap_cause;
      end
      A_COUNT:  rd_mux = DATA_W'(snap_cnt);
      A_LOAD:   rd_mux = DATA_W'(snap_load);
      A_KICK:   rd_mux = last_kick_q;
      A_PEND: begin
        rd_mux[PEND_LOAD_BIT] = load_busy;
        rd_mux[PEND_KICK_BIT] = kick_busy;
        rd_mux[PEND_ARM_BIT]  = arm_busy;
      end
      default:  rd_mux = '0;
    endcase
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk_i or negedge f_rst_n) begin
    if (!f_rst_n) begin
      last_kick_q <= '0;
      snap_q      <= {1'b0, 1'b0, LOAD_DEF, LOAD_DEF};
      rdata_q     <= '0;
    end else begin
      last_kick_q <= last_kick_d;
      snap_q      <= snap_d;
      rdata_q     <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;

  // R8
  kick_same_chk: assert property (@(posedge clk_i) disable iff (!f_rst_n)
    (wr_en && bus_addr_i == A_KICK && kick_same && !kick_busy) |=> !kick_busy);

  // R6
  pend_load_chk: assert property (@(posedge clk_i) disable iff (!f_rst_n)
    (wr_en && bus_addr_i == A_LOAD && !load_busy) |=> load_busy);

  // R11
  id_read_chk: assert property (@(posedge clk_i) disable iff (!f_rst_n)
    (rd_en && bus_addr_i == A_ID) |=> (bus_rdata_o == DATA_W'(ID_VALUE)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!f_rst_n)
    !rd_en |=> $stable(bus_rdata_o));
endmodule

// File: tb/wdt_unlock_test.sv
module wdt_unlock_test;
  localparam int AW = 5;
  localparam int RSTC = 8;
  localparam logic [31:0] DEF = 32'hFFF0_0000;
  localparam logic [31:0] IDV = 32'h5744_0001;
  localparam logic [AW-1:0] A_ID = 5'h00, A_STAT = 5'h04, A_CNT = 5'h08,
    A_LOAD = 5'h0C, A_KICK = 5'h10, A_PEND = 5'h14, A_ARM = 5'h18, A_NONE = 5'h1C;

  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic wrst;

  int compared = 0, mismatched = 0;
  bit rst_allowed = 1'b0, live = 1'b0, done = 1'b0;

  // behavioural model state
  logic [31:0] m_load = DEF, m_last_kick = 32'h0;
  int m_run = 0, m_cause = 0;

  wdt_unlock #(.RST_CYCLES(RSTC), .ID_VALUE(IDV)) uut (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wdt_rst_o(wrst)
  );

  always #2 clk = ~clk;
  initial begin
    #7;
    forever #20 slow_clk = ~slow_clk;
  end

  // per-clock comparison of the reset output against the model (R9)
  always @(negedge clk) begin
    if (live && !done) begin
      compared++;
      if (wrst && !rst_allowed) begin
        mismatched++;
        $display("FAIL R9: wdt_rst_o act=1 exp=0 at %0t", $time);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input logic [31:0] act,
                           input logic [31:0] lo, input logic [31:0] hi);
    compared++;
    if (act < lo || act > hi) begin
      mismatched++;
      $display("FAIL %s: act=%0d exp=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bwr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic brd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic wait_idle(input string req, input logic [31:0] mask);
    logic [31:0] v;
    v = mask;
    for (int i = 0; i < 300 && (v & mask) != 0; i++) brd(A_PEND, v);
    check(req, v & mask, 32'h0);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] d);
    bwr(A_ARM, d);
    wait_idle("R6", 32'h10);
  endtask

  initial begin
    logic [31:0] v, c1, c2;
    int n;
    #50;
    @(negedge clk);
    rst_n = 1'b1;
    wait_clk(20);
    live = 1'b1;

    // R1 reset state
    brd(A_ID, v);   check("R1", v, IDV);
    brd(A_STAT, v); check("R1", v, 32'h0);
    brd(A_PEND, v); check("R1", v, 32'h0);
    brd(A_LOAD, v); check("R1", v, m_load);
    brd(A_CNT, v);  check("R1", v, DEF);
    check("R1", {31'h0, wrst}, 32'h0);
    // R11 unmapped read
    brd(A_NONE, v); check("R11", v, 32'h0);

    // R6 load pending, R7 drop while pending
    bwr(A_LOAD, 32'hFFFF_F000);
    m_load = 32'hFFFF_F000;
    brd(A_PEND, v); check("R6", v, 32'h4);
    bwr(A_LOAD, 32'h1234_5678); // dropped (R7)
    wait_idle("R6", 32'h4);
    wait_clk(100);
    brd(A_LOAD, v); check("R7", v, m_load);

    // R5 broken sequence keeps counter stopped
    arm(32'h0000_BBBB);
    arm(32'h0000_1234);
    arm(32'h0000_4444);
    wait_clk(100);
    brd(A_STAT, v); check("R5", v, 32'h0);

    // R3 plain start
    arm(32'h0000_BBBB);
    bwr(A_ARM, 32'h0000_4444);
    brd(A_PEND, v); check("R6", v, 32'h10);
    wait_idle("R6", 32'h10);
    m_run = 1;
    wait_clk(100);
    brd(A_STAT, v); check("R3", v, 32'h1);
    brd(A_CNT, c1); check_rng("R3", c1 - m_load, 0, 40);

    // R2 / R10 count rate and monotonic snapshot
    wait_clk(1000);
    brd(A_CNT, c2);
    check_rng("R2", c2 - c1, 90, 110);
    check("R10", {31'h0, (c2 > c1)}, 32'h1);

    // R8 kick with a new value reloads
    bwr(A_KICK, 32'h0000_EDCB);
    m_last_kick = 32'h0000_EDCB;
    brd(A_PEND, v); check("R6", v, 32'h8);
    wait_idle("R8", 32'h8);
    wait_clk(100);
    brd(A_CNT, v); check_rng("R8", v - m_load, 0, 30);
    brd(A_KICK, v); check("R8", v, m_last_kick);

    // R8 same value: no pending bit, no reload
    wait_clk(1000);
    bwr(A_KICK, 32'h0000_EDCB);
    brd(A_PEND, v); check("R8", v, 32'h0);
    wait_clk(100);
    brd(A_CNT, v); check_rng("R8", v - m_load, 60, 200);

    // R8 complement reloads again
    bwr(A_KICK, 32'h0000_1234);
    m_last_kick = 32'h0000_1234;
    wait_idle("R8", 32'h8);
    wait_clk(100);
    brd(A_CNT, v); check_rng("R8", v - m_load, 0, 30);

    // R4 stop freezes the counter
    arm(32'h0000_AAAA);
    arm(32'h0000_5555);
    m_run = 0;
    wait_clk(100);
    brd(A_STAT, v); check("R4", v, 32'h0);
    brd(A_CNT, c1);
    wait_clk(500);
    brd(A_CNT, c2); check("R4", c2, c1);

    // R9 overflow, started through a re-armed first word (R3)
    bwr(A_LOAD, 32'hFFFF_FFF0);
    m_load = 32'hFFFF_FFF0;
    wait_idle("R6", 32'h4);
    arm(32'h0000_BBBB);
    arm(32'h0000_BBBB);
    rst_allowed = 1'b1;
    bwr(A_ARM, 32'h0000_4444);
    n = 0;
    for (int i = 0; i < 5000 && !wrst; i++) @(negedge clk);
    check("R9", {31'h0, wrst}, 32'h1);
    if (wrst) begin
      do begin
        @(negedge slow_clk);
        if (wrst) n++;
      end while (wrst);
    end
    check("R9", n, RSTC);
    rst_allowed = 1'b0;
    m_run = 0; m_cause = 1; m_load = DEF;
    wait_clk(100);
    brd(A_STAT, v); check("R9", v, {30'h0, m_cause[0], m_run[0]});
    brd(A_LOAD, v); check("R9", v, m_load);
    brd(A_CNT, v);  check("R9", v, DEF);
    wait_clk(200);
    brd(A_STAT, v); check("R9", v, 32'h2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule